// File: doc/BRIEF.md
# Configurable Memory Map Decoder

This block sits between a small 8-bit processor core and its memories. Each access carries a 16-bit address. It is either a data-space access (read or write) or an instruction fetch. The block decides where the access goes. The possible targets are a 1 KB on-chip data SRAM (modelled inside the block), an on-chip program memory, the external expanded bus, or a fixed read-only system control byte. It raises exactly one select strobe for the chosen target. When no target applies, it raises a reserved flag instead.

Two software-written fields steer the routing:

- **Data-map mode** is a 2-bit field. It chooses between four data maps: everything external, a split between internal SRAM and the external bus, a reserved setting, and internal SRAM plus a read-only control byte.
- **Program-size code** is a 3-bit field. It sets how much of the low program space is served on chip; fetches at or above that limit go off chip.

A new program-size code only steers fetches after a fixed delay of two cycles. Every accepted access runs through a two-cycle handshake (`busy`, then `done`). While an external access is in flight, `port_busy` is raised to mark the address/data ports as owned by the bus.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset the data-map mode is 00, and every data address 0000h–FFFFh selects the external bus. The program-size code resets to 101 (full 16 KB on chip).
- R2: In data-map mode 01, data addresses 0000h–03FFh select the internal SRAM and 0400h–FFFFh select the external bus.
- R3: In data-map mode 10, every data access raises `rsv_flag` and no select strobe.
- R4: In data-map mode 11, 0000h–03FFh select the SRAM, and FFFCh selects the control byte, which reads back as parameter value 5Ah. The ranges 0400h–FFFBh and FFFDh–FFFFh raise `rsv_flag`.
- R5: A write to FFFCh in mode 11 leaves the value read from FFFCh unchanged. Changing the data-map mode never changes the SRAM contents.
- R6: An accepted access (`acc_valid` while `busy` is low) holds `busy` for exactly two cycles. `done` is high in the second of them only; with no access in flight, all strobes, `rsv_flag` and `done` are low.
- R7: A fetch goes to on-chip program memory when its address is below the limit set by the program-size code, and to the external bus otherwise. The codes map as 000=0 KB, 001=1 KB, 010=2 KB, 011=4 KB, 100=8 KB, 101=16 KB; 110 and 111 clamp to 16 KB.
- R8: A program-size write at clock edge w still steers fetches accepted at edges w and w+1 with the old code. Fetches accepted from edge w+2 on use the new code.
- R9: An access in flight asserts at most one select. Exactly one select is asserted unless `rsv_flag` is set. `port_busy` is high exactly while an external-bus access is in flight.
- R10: In the `done` cycle, `rd_data` carries the SRAM word, `rom_rdata`, `ext_rdata` or the control byte, according to the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dm_we | input | 1 | Write strobe for the data-map mode |
| dm_wdata | input | 2 | New data-map mode |
| rs_we | input | 1 | Write strobe for the program-size code |
| rs_wdata | input | 3 | New program-size code |
| acc_valid | input | 1 | Access request |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_write | input | 1 | Data write (ignored for fetches) |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| ext_rdata | input | 8 | Read data from the external bus |
| rom_rdata | input | 8 | Read data from on-chip program memory |
| busy | output | 1 | Access in flight |
| done | output | 1 | Second cycle of an access; `rd_data` valid |
| sel_sram | output | 1 | Internal SRAM selected |
| sel_rom | output | 1 | On-chip program memory selected |
| sel_ext | output | 1 | External bus selected |
| sel_scb | output | 1 | System control byte selected |
| rsv_flag | output | 1 | Reserved/illegal access |
| port_busy | output | 1 | Ports owned by an external access |
| mem_addr | output | 16 | Address of the access in flight |
| mem_wdata | output | 8 | Write data of the access in flight |
| ext_wr | output | 1 | External write strobe |
| rd_data | output | 8 | Read data |

## Verification
The bench probes the edges of each window: 03FFh versus 0400h, FFFBh, FFFCh and FFFDh in mode 11, and 3FFFh versus 4000h for fetches. A decoder with an off-by-one compare would route the boundary word to the wrong target.

It writes FFFCh and then reads it back. A design that let the write through would no longer return 5Ah. It stores a byte in SRAM and then cycles the data-map mode through 00 and back. Any reset or clear on a mode change would lose the byte.

It starts fetches one and two edges after a program-size write. A design with the wrong delay would switch limits one access early or late. It also uses codes 000 and 111, where a missing clamp or a missing zero-size case would misroute the fetch.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  typedef enum logic [1:0] {
    DM_ALL_EXT = 2'b00,
    DM_SPLIT   = 2'b01,
    DM_RSVD    = 2'b10,
    DM_CTRL    = 2'b11
  } dmap_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2
  } phase_e;

  typedef struct packed {
    logic sram;
    logic rom;
    logic ext;
    logic scb;
    logic rsv;
  } route_t;

endpackage

// File: rtl/mmd_cfg.sv
module mmd_cfg
  import mmd_pkg::*;
#(
  parameter int              CODE_W   = 3,
  parameter int              LAT      = 2,
  parameter logic [CODE_W-1:0] CODE_RST = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dm_we,
  input  logic [1:0]        dm_wdata,
  input  logic              rs_we,
  input  logic [CODE_W-1:0] rs_wdata,
  output dmap_e             dmap,
  output logic [CODE_W-1:0] code_eff
);

  dmap_e             dmap_q, dmap_d;
  logic [CODE_W-1:0] stg_q [LAT];
  logic [CODE_W-1:0] stg_d [LAT];

  always_comb begin
    dmap_d = dmap_q;
    if (dm_we) dmap_d = dmap_e'(dm_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dmap_q <= DM_ALL_EXT;
    else        dmap_q <= dmap_d;
  end

  // Program-size code pipeline: the last stage is the live value.
  generate
    for (genvar i = 0; i < LAT; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_comb stg_d[i] = rs_we ? rs_wdata : stg_q[i];
      end else begin : g_tail
        always_comb stg_d[i] = stg_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= CODE_RST;
        else        stg_q[i] <= stg_d[i];
      end
    end
  endgenerate

  assign dmap     = dmap_q;
  assign code_eff = stg_q[LAT-1];

endmodule

// File: rtl/mmd_decode.sv
module mmd_decode
  import mmd_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              CODE_W     = 3,
  parameter int              SRAM_WORDS = 1024,
  parameter int              ROM_KB     = 16,
  parameter logic [ADDR_W-1:0] SCB_ADDR = 16'hFFFC
) (
  input  logic              is_fetch,
  input  logic [ADDR_W-1:0] addr,
  input  dmap_e             dmap,
  input  logic [CODE_W-1:0] code,
  output route_t            route
);

  localparam logic [31:0] SRAM_TOP = 32'(SRAM_WORDS);
  localparam logic [31:0] ROM_MAX  = 32'(ROM_KB);

  logic [31:0] addr_w;
  logic [31:0] kb;
  logic [31:0] limit;
  logic        in_sram;

  assign addr_w  = 32'(addr);
  assign in_sram = addr_w < SRAM_TOP;

  // Program-size code to byte limit: 0 -> 0 KB, c -> 2^(c-1) KB, clamped.
  always_comb begin
    if (code == '0) kb = 32'd0;
    else            kb = 32'd1 << (32'(code) - 32'd1);
    if (kb > ROM_MAX) kb = ROM_MAX;
    limit = kb << 10;
  end

  always_comb begin
    route = '0;
    if (is_fetch) begin
      if (addr_w < limit) route.rom = 1'b1;
      else                route.ext = 1'b1;
    end else begin
      unique case (dmap)
        DM_ALL_EXT: route.ext = 1'b1;
        DM_SPLIT: begin
          if (in_sram) route.sram = 1'b1;
          else         route.ext  = 1'b1;
        end
        DM_RSVD: route.rsv = 1'b1;
        DM_CTRL: begin
          if (in_sram)               route.sram = 1'b1;
          else if (addr == SCB_ADDR) route.scb  = 1'b1;
          else                       route.rsv  = 1'b1;
        end
        default: route.rsv = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/mmd_sram.sv
module mmd_sram #(
  parameter int WORDS = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         DW         = 8,
  parameter int         CODE_W     = 3,
  parameter int         SRAM_WORDS = 1024,
  parameter int         ROM_KB     = 16,
  parameter int         CODE_LAT   = 2,
  parameter logic [7:0] SCB_VALUE  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dm_we,
  input  logic [1:0]        dm_wdata,
  input  logic              rs_we,
  input  logic [CODE_W-1:0] rs_wdata,
  input  logic              acc_valid,
  input  logic              acc_fetch,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  input  logic [DW-1:0]     ext_rdata,
  input  logic [DW-1:0]     rom_rdata,
  output logic              busy,
  output logic              done,
  output logic              sel_sram,
  output logic              sel_rom,
  output logic              sel_ext,
  output logic              sel_scb,
  output logic              rsv_flag,
  output logic              port_busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              ext_wr,
  output logic [DW-1:0]     rd_data
);

  localparam int                SRAM_AW  = $clog2(SRAM_WORDS);
  localparam logic [ADDR_W-1:0] SCB_ADDR = {{(ADDR_W-2){1'b1}}, 2'b00};

  dmap_e             dmap;
  logic [CODE_W-1:0] code_eff;
  route_t            route_new, route_q, route_d;
  phase_e            ph_q, ph_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DW-1:0]     wd_q, wd_d;
  logic              wr_q, wr_d;
  logic              accept;
  logic              ram_en, ram_we;
  logic [DW-1:0]     ram_rdata;

  mmd_cfg #(
    .CODE_W  (CODE_W),
    .LAT     (CODE_LAT),
    .CODE_RST(CODE_W'(5))
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .dm_we   (dm_we),
    .dm_wdata(dm_wdata),
    .rs_we   (rs_we),
    .rs_wdata(rs_wdata),
    .dmap    (dmap),
    .code_eff(code_eff)
  );

  mmd_decode #(
    .ADDR_W    (ADDR_W),
    .CODE_W    (CODE_W),
    .SRAM_WORDS(SRAM_WORDS),
    .ROM_KB    (ROM_KB),
    .SCB_ADDR  (SCB_ADDR)
  ) u_dec (
    .is_fetch(acc_fetch),
    .addr    (acc_addr),
    .dmap    (dmap),
    .code    (code_eff),
    .route   (route_new)
  );

  // Access sequencer: idle -> first cycle -> second cycle (done).
  assign accept = acc_valid && (ph_q == PH_IDLE);

  always_comb begin
    ph_d    = ph_q;
    addr_d  = addr_q;
    wd_d    = wd_q;
    wr_d    = wr_q;
    route_d = route_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d    = PH_ONE;
          addr_d  = acc_addr;
          wd_d    = acc_wdata;
          wr_d    = acc_write && !acc_fetch;
          route_d = route_new;
        end
      end
      PH_ONE:  ph_d = PH_TWO;
      PH_TWO:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      addr_q  <= '0;
      wd_q    <= '0;
      wr_q    <= 1'b0;
      route_q <= '0;
    end else begin
      ph_q    <= ph_d;
      addr_q  <= addr_d;
      wd_q    <= wd_d;
      wr_q    <= wr_d;
      route_q <= route_d;
    end
  end

  assign ram_en = (ph_q == PH_ONE) && route_q.sram;
  assign ram_we = ram_en && wr_q;

  mmd_sram #(
    .WORDS(SRAM_WORDS),
    .DW   (DW)
  ) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (addr_q[SRAM_AW-1:0]),
    .wdata(wd_q),
    .rdata(ram_rdata)
  );

  assign busy      = (ph_q != PH_IDLE);
  assign done      = (ph_q == PH_TWO);
  assign sel_sram  = busy && route_q.sram;
  assign sel_rom   = busy && route_q.rom;
  assign sel_ext   = busy && route_q.ext;
  assign sel_scb   = busy && route_q.scb;
  assign rsv_flag  = busy && route_q.rsv;
  assign port_busy = sel_ext;
  assign ext_wr    = sel_ext && wr_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;

  always_comb begin
    rd_data = '0;
    if (done) begin
      if (route_q.sram)     rd_data = ram_rdata;
      else if (route_q.rom) rd_data = rom_rdata;
      else if (route_q.ext) rd_data = ext_rdata;
      else if (route_q.scb) rd_data = SCB_VALUE;
    end
  end

endmodule

// File: rtl/mmd_checker.sv
module mmd_checker #(
  parameter int ADDR_W     = 16,
  parameter int SRAM_WORDS = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              sel_sram,
  input logic              sel_rom,
  input logic              sel_ext,
  input logic              sel_scb,
  input logic              rsv_flag,
  input logic              port_busy,
  input logic [ADDR_W-1:0] mem_addr
);

  logic [3:0] sels;
  assign sels = {sel_sram, sel_rom, sel_ext, sel_scb};

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot0(sels)); // R9
  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsv_flag) |-> ($countones(sels) == 1)); // R9
  AST_PORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |-> busy); // R9
  AST_RSV_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_flag |-> (sels == 4'b0000)); // R3
  AST_DONE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sels == 4'b0000 && !rsv_flag && !done)); // R6
  AST_SRAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sram |-> (32'(mem_addr) < 32'(SRAM_WORDS))); // R2
  AST_SCB_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_scb |-> (mem_addr == {{(ADDR_W-2){1'b1}}, 2'b00})); // R4

endmodule

bind mem_map_decoder mmd_checker #(
  .ADDR_W    (ADDR_W),
  .SRAM_WORDS(SRAM_WORDS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .sel_sram (sel_sram),
  .sel_rom  (sel_rom),
  .sel_ext  (sel_ext),
  .sel_scb  (sel_scb),
  .rsv_flag (rsv_flag),
  .port_busy(port_busy),
  .mem_addr (mem_addr)
);

// File: tb/mem_map_decoder_tb.sv
`timescale 1ns/1ps
module mem_map_decoder_tb;

  localparam logic [7:0] SCB  = 8'h5A;
  localparam logic [7:0] EXTD = 8'h3C;
  localparam logic [7:0] ROMD = 8'hC3;

  logic        clk, rst_n;
  logic        dm_we, rs_we, acc_valid, acc_fetch, acc_write;
  logic [1:0]  dm_wdata;
  logic [2:0]  rs_wdata;
  logic [15:0] acc_addr, mem_addr;
  logic [7:0]  acc_wdata, ext_rdata, rom_rdata, mem_wdata, rd_data;
  logic        busy, done, sel_sram, sel_rom, sel_ext, sel_scb;
  logic        rsv_flag, port_busy, ext_wr;

  mem_map_decoder u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [4:0] route;   // {sram, rom, ext, scb, rsv}
    bit         chk;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   ended = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference routing, derived from the requirements.
  function automatic logic [4:0] model(input bit f, input logic [15:0] a,
                                       input logic [1:0] m, input logic [2:0] c);
    int lim;
    if (f) begin
      lim = (c == 0) ? 0 : ((c >= 5) ? 16 : (1 << (c - 1)));
      return (int'(a) < lim * 1024) ? 5'b01000 : 5'b00100;
    end
    case (m)
      2'b00: return 5'b00100;
      2'b01: return (a < 16'h0400) ? 5'b10000 : 5'b00100;
      2'b10: return 5'b00001;
      default: return (a < 16'h0400) ? 5'b10000 :
                      (a == 16'hFFFC) ? 5'b00010 : 5'b00001;
    endcase
  endfunction

  // Monitor: pops an expected item each time an access completes.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        exp_t e;
        logic [4:0] act;
        e   = exp_q.pop_front();
        act = {sel_sram, sel_rom, sel_ext, sel_scb, rsv_flag};
        check(act == e.route, e.tag, 32'(act), 32'(e.route));
        check(port_busy == e.route[2], "R9 port_busy", 32'(port_busy), 32'(e.route[2]));
        if (e.chk) check(rd_data == e.data, {e.tag, " R10 data"}, 32'(rd_data), 32'(e.data));
      end
    end
  end

  // Driver: entered and left at a falling edge.
  task automatic access(input bit f, input bit w, input logic [15:0] a,
                        input logic [7:0] wd, input logic [1:0] m,
                        input logic [2:0] c, input bit chk,
                        input logic [7:0] ed, input string tag);
    exp_t e;
    e.route = model(f, a, m, c);
    e.chk   = chk;
    e.data  = ed;
    e.tag   = tag;
    exp_q.push_back(e);
    acc_valid = 1'b1; acc_fetch = f; acc_write = w; acc_addr = a; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check(busy && !done, "R6 first cycle", {busy, done}, 2'b10);
    @(negedge clk);
    check(busy && done, "R6 second cycle", {busy, done}, 2'b11);
    @(negedge clk);
    check(!busy && !done, "R6 back to idle", {busy, done}, 2'b00);
  endtask

  task automatic set_mode(input logic [1:0] m);
    dm_we = 1'b1; dm_wdata = m;
    @(negedge clk);
    dm_we = 1'b0;
  endtask

  task automatic set_code(input logic [2:0] c);
    rs_we = 1'b1; rs_wdata = c;
    @(negedge clk);
    rs_we = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dm_we = 1'b0; rs_we = 1'b0; dm_wdata = '0; rs_wdata = '0;
    acc_valid = 1'b0; acc_fetch = 1'b0; acc_write = 1'b0; acc_addr = '0;
    acc_wdata = '0; ext_rdata = EXTD; rom_rdata = ROMD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, sel_sram, sel_rom, sel_ext, sel_scb, rsv_flag, port_busy} == 8'h00,
          "R6 reset idle", {busy, done}, 0);

    // R1: default map all external, default program size full
    access(0, 0, 16'h0000, 0, 2'b00, 3'd5, 1, EXTD, "R1 data 0000");
    access(0, 1, 16'hFFFF, 8'h11, 2'b00, 3'd5, 0, 0, "R1 data FFFF");
    access(1, 0, 16'h3FFF, 0, 2'b00, 3'd5, 1, ROMD, "R1 R7 fetch 3FFF");
    access(1, 0, 16'h4000, 0, 2'b00, 3'd5, 1, EXTD, "R7 fetch 4000");

    // R2: split map
    set_mode(2'b01);
    access(0, 1, 16'h0010, 8'hA5, 2'b01, 3'd5, 0, 0, "R2 write 0010");
    access(0, 0, 16'h0010, 0, 2'b01, 3'd5, 1, 8'hA5, "R2 read 0010");
    access(0, 1, 16'h03FF, 8'h77, 2'b01, 3'd5, 0, 0, "R2 write 03FF");
    access(0, 0, 16'h03FF, 0, 2'b01, 3'd5, 1, 8'h77, "R2 read 03FF");
    access(0, 0, 16'h0400, 0, 2'b01, 3'd5, 1, EXTD, "R2 read 0400");

    // R3: reserved mode
    set_mode(2'b10);
    access(0, 0, 16'h0010, 0, 2'b10, 3'd5, 0, 0, "R3 read 0010");
    access(0, 1, 16'h8000, 8'h01, 2'b10, 3'd5, 0, 0, "R3 write 8000");

    // R4/R5: internal plus control byte
    set_mode(2'b11);
    access(0, 0, 16'h0010, 0, 2'b11, 3'd5, 1, 8'hA5, "R4 R5 read 0010");
    access(0, 0, 16'hFFFC, 0, 2'b11, 3'd5, 1, SCB, "R4 read FFFC");
    access(0, 1, 16'hFFFC, 8'h00, 2'b11, 3'd5, 0, 0, "R5 write FFFC");
    access(0, 0, 16'hFFFC, 0, 2'b11, 3'd5, 1, SCB, "R5 reread FFFC");
    access(0, 0, 16'h0400, 0, 2'b11, 3'd5, 0, 0, "R4 0400 reserved");
    access(0, 0, 16'hFFFB, 0, 2'b11, 3'd5, 0, 0, "R4 FFFB reserved");
    access(0, 0, 16'hFFFD, 0, 2'b11, 3'd5, 0, 0, "R4 FFFD reserved");

    // R5: SRAM survives mode changes
    set_mode(2'b00);
    access(0, 0, 16'h0010, 0, 2'b00, 3'd5, 1, EXTD, "R1 ext after change");
    set_mode(2'b01);
    access(0, 0, 16'h0010, 0, 2'b01, 3'd5, 1, 8'hA5, "R5 retained 0010");
    access(0, 0, 16'h03FF, 0, 2'b01, 3'd5, 1, 8'h77, "R5 retained 03FF");

    // R7/R8: program-size code and its delay
    set_code(3'd0);                      // write edge w; next accept at w+1
    access(1, 0, 16'h0000, 0, 2'b01, 3'd5, 1, ROMD, "R8 old code at w+1");
    access(1, 0, 16'h0000, 0, 2'b01, 3'd0, 1, EXTD, "R7 code 000");
    set_code(3'd3);
    @(negedge clk);                      // accept at w+2
    access(1, 0, 16'h0FFF, 0, 2'b01, 3'd3, 1, ROMD, "R8 new code at w+2");
    access(1, 0, 16'h1000, 0, 2'b01, 3'd3, 1, EXTD, "R7 code 011 limit");
    set_code(3'd7);
    @(negedge clk);
    access(1, 0, 16'h3FFF, 0, 2'b01, 3'd7, 1, ROMD, "R7 code 111 clamp");
    access(1, 0, 16'h4000, 0, 2'b01, 3'd7, 1, EXTD, "R7 code 111 above");
    access(1, 1, 16'h0020, 8'h99, 2'b01, 3'd7, 1, ROMD, "R7 fetch ignores write");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R6 all accesses completed", exp_q.size(), 0);
    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule